// File: doc/BRIEF.md
# ADC Calibration Result Validator

This block judges the words left behind by the self-calibration of a successive-approximation converter. It takes one signed offset word, two small signed trim words, and five unsigned capacitor-weight words. It compares each one against its allowed window and reduces the outcome to a single failed flag. Some of the windows are fixed. Others are derived from the word one step lower in the weight chain.

All comparisons run in parallel and combinationally on the input words. The result is captured into the output flag only when the producer pulses the valid strobe. The flag then holds until the next strobe or a reset. Software or a sequencer can sample it at any later time.

Top module: `adc_cal_validator`

## Requirements
- R1: After synchronous active-high reset `cal_fail` is 0. When `rst` and `in_valid` are both high in the same cycle, reset wins and `cal_fail` is 0 afterwards.
- R2: `cal_fail` takes a new value only on the clock edge where `in_valid` is high, and shows it from the next cycle on. Input changes without a strobe leave it unchanged.
- R3: `ofs_word` is 16-bit two's complement. It passes only when it lies in -48 to +22 inclusive.
- R4: `trim_a` is 7-bit two's complement. It passes only when it lies in -12 to +20 inclusive.
- R5: `trim_b` is 7-bit two's complement. It passes only when it lies in -16 to +16 inclusive.
- R6: `wt_base` is unsigned. It passes only when it lies in 30 to 120 inclusive.
- R7: `wt0` passes only when it is within 14 of `wt_base`, inclusive at both ends.
- R8: `wt1` passes only when it is within 16 of twice `wt0`, inclusive.
- R9: `wt2` passes only when it is within 20 of (twice `wt1` minus 26), inclusive.
- R10: `wt3` passes only when it is within 36 of twice `wt2`, inclusive.
- R11: Failing any single window sets the flag, as does failing several at once. Derived windows are computed signed and at least 12 bits wide, so a window whose lower edge lies below zero accepts small words rather than wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: capture the verdict on this edge |
| ofs_word | input | 16 | Signed offset word |
| trim_a | input | 7 | First signed trim word |
| trim_b | input | 7 | Second signed trim word |
| wt_base | input | 10 | Unsigned base weight word |
| wt0 | input | 10 | Weight word 0 |
| wt1 | input | 10 | Weight word 1 |
| wt2 | input | 10 | Weight word 2 |
| wt3 | input | 10 | Weight word 3 |
| cal_fail | output | 1 | Registered calibration-failed flag |

## Verification
Two things can land in one cycle. The first is a strobe together with reset. The bench first latches a failing verdict, then raises `rst` and `in_valid` on the same edge with a failing vector. It expects the flag to read 0, which shows that reset takes priority. The second is several window violations on one strobe. A vector that breaks the offset, trim and weight windows together must still give a plain set flag. Every window is probed one step inside and one step outside each edge, with the rest of the chain held legal so that only the word under test decides the result.

// File: rtl/adc_cal_validator_pkg.sv
package adc_cal_validator_pkg;

  function automatic int max_int(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Half-width of the tolerance window for each weight stage.
  function automatic int stage_margin(input int s);
    case (s)
      0:       return 14;
      1:       return 16;
      2:       return 20;
      default: return 36;
    endcase
  endfunction

  // Constant pulled off the doubled lower word before the window is applied.
  function automatic int stage_adjust(input int s);
    return (s == 2) ? 26 : 0;
  endfunction

  // Stage 0 tracks the base word directly; later stages double it.
  function automatic bit stage_doubles(input int s);
    return s != 0;
  endfunction

endpackage

// File: rtl/adc_cal_validator_window.sv
module adc_cal_validator_window #(
  parameter int W = 8
) (
  input  logic signed [W-1:0] val,
  input  logic signed [W-1:0] lo,
  input  logic signed [W-1:0] hi,
  output logic                out_of_range
);
  always_comb out_of_range = (val < lo) || (val > hi);
endmodule

// File: rtl/adc_cal_validator_stage.sv
module adc_cal_validator_stage #(
  parameter int IN_W   = 10,
  parameter int CMP_W  = 13,
  parameter bit DOUBLE = 1'b1,
  parameter int ADJ    = 0,
  parameter int MARGIN = 16
) (
  input  logic [IN_W-1:0] prev_word,
  input  logic [IN_W-1:0] cur_word,
  output logic            stage_fail
);
  localparam int PAD = CMP_W - IN_W;
  localparam logic signed [CMP_W-1:0] ADJ_C    = CMP_W'(ADJ);
  localparam logic signed [CMP_W-1:0] MARGIN_C = CMP_W'(MARGIN);

  logic signed [CMP_W-1:0] prev_s, cur_s, center, lo, hi;

  always_comb begin
    prev_s = $signed({{PAD{1'b0}}, prev_word});
    cur_s  = $signed({{PAD{1'b0}}, cur_word});
    center = (DOUBLE ? (prev_s + prev_s) : prev_s) - ADJ_C;
    lo     = center - MARGIN_C;
    hi     = center + MARGIN_C;
  end

  adc_cal_validator_window #(.W(CMP_W)) u_win (
    .val          (cur_s),
    .lo           (lo),
    .hi           (hi),
    .out_of_range (stage_fail)
  );
endmodule

// File: rtl/adc_cal_validator.sv
module adc_cal_validator
  import adc_cal_validator_pkg::*;
#(
  parameter int OFS_W    = 16,
  parameter int TRIM_W   = 7,
  parameter int WGT_W    = 10,
  parameter int OFS_MIN  = -48,
  parameter int OFS_MAX  = 22,
  parameter int TA_MIN   = -12,
  parameter int TA_MAX   = 20,
  parameter int TB_MIN   = -16,
  parameter int TB_MAX   = 16,
  parameter int BASE_MIN = 30,
  parameter int BASE_MAX = 120
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OFS_W-1:0]  ofs_word,
  input  logic [TRIM_W-1:0] trim_a,
  input  logic [TRIM_W-1:0] trim_b,
  input  logic [WGT_W-1:0]  wt_base,
  input  logic [WGT_W-1:0]  wt0,
  input  logic [WGT_W-1:0]  wt1,
  input  logic [WGT_W-1:0]  wt2,
  input  logic [WGT_W-1:0]  wt3,
  output logic              cal_fail
);
  localparam int NSTG  = 4;
  localparam int NCHK  = NSTG + 4;
  localparam int CMP_W = max_int(12, WGT_W + 3);

  localparam logic signed [OFS_W-1:0]  OFS_LO  = OFS_W'(OFS_MIN);
  localparam logic signed [OFS_W-1:0]  OFS_HI  = OFS_W'(OFS_MAX);
  localparam logic signed [TRIM_W-1:0] TA_LO   = TRIM_W'(TA_MIN);
  localparam logic signed [TRIM_W-1:0] TA_HI   = TRIM_W'(TA_MAX);
  localparam logic signed [TRIM_W-1:0] TB_LO   = TRIM_W'(TB_MIN);
  localparam logic signed [TRIM_W-1:0] TB_HI   = TRIM_W'(TB_MAX);
  localparam logic signed [CMP_W-1:0]  BASE_LO = CMP_W'(BASE_MIN);
  localparam logic signed [CMP_W-1:0]  BASE_HI = CMP_W'(BASE_MAX);

  logic [NCHK-1:0]  fail_vec;
  logic [WGT_W-1:0] chain [NSTG+1];
  logic signed [CMP_W-1:0] base_s;

  always_comb begin
    chain[0] = wt_base;
    chain[1] = wt0;
    chain[2] = wt1;
    chain[3] = wt2;
    chain[4] = wt3;
    base_s   = $signed({{(CMP_W-WGT_W){1'b0}}, wt_base});
  end

  adc_cal_validator_window #(.W(OFS_W)) u_ofs (
    .val($signed(ofs_word)), .lo(OFS_LO), .hi(OFS_HI), .out_of_range(fail_vec[0]));

  adc_cal_validator_window #(.W(TRIM_W)) u_ta (
    .val($signed(trim_a)), .lo(TA_LO), .hi(TA_HI), .out_of_range(fail_vec[1]));

  adc_cal_validator_window #(.W(TRIM_W)) u_tb (
    .val($signed(trim_b)), .lo(TB_LO), .hi(TB_HI), .out_of_range(fail_vec[2]));

  adc_cal_validator_window #(.W(CMP_W)) u_base (
    .val(base_s), .lo(BASE_LO), .hi(BASE_HI), .out_of_range(fail_vec[3]));

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    adc_cal_validator_stage #(
      .IN_W   (WGT_W),
      .CMP_W  (CMP_W),
      .DOUBLE (stage_doubles(g)),
      .ADJ    (stage_adjust(g)),
      .MARGIN (stage_margin(g))
    ) u_stage (
      .prev_word  (chain[g]),
      .cur_word   (chain[g+1]),
      .stage_fail (fail_vec[4+g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)           cal_fail <= 1'b0;
    else if (in_valid) cal_fail <= |fail_vec;
  end
endmodule

// File: rtl/adc_cal_validator_chk.sv
module adc_cal_validator_chk #(
  parameter int OFS_W    = 16,
  parameter int TRIM_W   = 7,
  parameter int WGT_W    = 10,
  parameter int OFS_MIN  = -48,
  parameter int OFS_MAX  = 22,
  parameter int TA_MIN   = -12,
  parameter int TA_MAX   = 20,
  parameter int TB_MIN   = -16,
  parameter int TB_MAX   = 16,
  parameter int BASE_MIN = 30,
  parameter int BASE_MAX = 120
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [OFS_W-1:0]  ofs_word,
  input logic [TRIM_W-1:0] trim_a,
  input logic [TRIM_W-1:0] trim_b,
  input logic [WGT_W-1:0]  wt_base,
  input logic [WGT_W-1:0]  wt0,
  input logic [WGT_W-1:0]  wt1,
  input logic [WGT_W-1:0]  wt2,
  input logic [WGT_W-1:0]  wt3,
  input logic              cal_fail
);
  int ofs_i, ta_i, tb_i, base_i, w0_i;
  always_comb begin
    ofs_i  = int'($signed(ofs_word));
    ta_i   = int'($signed(trim_a));
    tb_i   = int'($signed(trim_b));
    base_i = int'(wt_base);
    w0_i   = int'(wt0);
  end

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> !cal_fail);

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(cal_fail));

  p_offset_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (ofs_i < OFS_MIN || ofs_i > OFS_MAX)) |=> cal_fail);

  p_trim_a_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (ta_i < TA_MIN || ta_i > TA_MAX)) |=> cal_fail);

  p_trim_b_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (tb_i < TB_MIN || tb_i > TB_MAX)) |=> cal_fail);

  p_base_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (base_i < BASE_MIN || base_i > BASE_MAX)) |=> cal_fail);

  p_w0_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (w0_i < base_i - 14 || w0_i > base_i + 14)) |=> cal_fail);
endmodule

bind adc_cal_validator adc_cal_validator_chk #(
  .OFS_W(OFS_W), .TRIM_W(TRIM_W), .WGT_W(WGT_W),
  .OFS_MIN(OFS_MIN), .OFS_MAX(OFS_MAX), .TA_MIN(TA_MIN), .TA_MAX(TA_MAX),
  .TB_MIN(TB_MIN), .TB_MAX(TB_MAX), .BASE_MIN(BASE_MIN), .BASE_MAX(BASE_MAX)
) u_chk (.*);

// File: tb/adc_cal_validator_test.sv
`timescale 1ns/1ps
module adc_cal_validator_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [15:0] ofs_word = '0;
  logic [6:0]  trim_a = '0, trim_b = '0;
  logic [9:0]  wt_base = '0, wt0 = '0, wt1 = '0, wt2 = '0, wt3 = '0;
  logic        cal_fail;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  adc_cal_validator uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .ofs_word(ofs_word),
    .trim_a(trim_a), .trim_b(trim_b), .wt_base(wt_base), .wt0(wt0),
    .wt1(wt1), .wt2(wt2), .wt3(wt3), .cal_fail(cal_fail));

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: cal_fail act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic set_words(input int o, input int a, input int b, input int bs,
                           input int x0, input int x1, input int x2, input int x3);
    ofs_word = 16'(o); trim_a = 7'(a); trim_b = 7'(b);
    wt_base = 10'(bs); wt0 = 10'(x0); wt1 = 10'(x1); wt2 = 10'(x2); wt3 = 10'(x3);
  endtask

  // Strobe one vector and check the flag in the cycle after the capturing edge.
  task automatic run(input string req, input int o, input int a, input int b, input int bs,
                     input int x0, input int x1, input int x2, input int x3, input logic exp);
    @(negedge clk);
    set_words(o, a, b, bs, x0, x1, x2, x3);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, cal_fail, exp);
  endtask

  task automatic run_nominal(input string req, input logic exp);
    run(req, -8, 4, 0, 72, 72, 144, 262, 524, exp);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R1 reset value", cal_fail, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_offset;
    run("R3 ofs -48", -48, 4, 0, 72, 72, 144, 262, 524, 1'b0);
    run("R3 ofs -49", -49, 4, 0, 72, 72, 144, 262, 524, 1'b1);
    run("R3 ofs 22",   22, 4, 0, 72, 72, 144, 262, 524, 1'b0);
    run("R3 ofs 23",   23, 4, 0, 72, 72, 144, 262, 524, 1'b1);
    run("R3 ofs min", -32768, 4, 0, 72, 72, 144, 262, 524, 1'b1);
  endtask

  task automatic t_trims;
    run("R4 ta -12", -8, -12, 0, 72, 72, 144, 262, 524, 1'b0);
    run("R4 ta -13", -8, -13, 0, 72, 72, 144, 262, 524, 1'b1);
    run("R4 ta 20",  -8,  20, 0, 72, 72, 144, 262, 524, 1'b0);
    run("R4 ta 21",  -8,  21, 0, 72, 72, 144, 262, 524, 1'b1);
    run("R5 tb -16", -8, 4, -16, 72, 72, 144, 262, 524, 1'b0);
    run("R5 tb -17", -8, 4, -17, 72, 72, 144, 262, 524, 1'b1);
    run("R5 tb 16",  -8, 4,  16, 72, 72, 144, 262, 524, 1'b0);
    run("R5 tb 17",  -8, 4,  17, 72, 72, 144, 262, 524, 1'b1);
  endtask

  task automatic t_base;
    run("R6 base 30",  -8, 4, 0, 30,  30,  60,  94, 188, 1'b0);
    run("R6 base 29",  -8, 4, 0, 29,  30,  60,  94, 188, 1'b1);
    run("R6 base 120", -8, 4, 0, 120, 120, 240, 454, 908, 1'b0);
    run("R6 base 121", -8, 4, 0, 121, 120, 240, 454, 908, 1'b1);
  endtask

  task automatic t_chain;
    run("R7 w0 58", -8, 4, 0, 72, 58, 116, 206, 412, 1'b0);
    run("R7 w0 57", -8, 4, 0, 72, 57, 114, 202, 404, 1'b1);
    run("R7 w0 86", -8, 4, 0, 72, 86, 172, 318, 636, 1'b0);
    run("R7 w0 87", -8, 4, 0, 72, 87, 174, 322, 644, 1'b1);
    run("R8 w1 160", -8, 4, 0, 72, 72, 160, 294, 588, 1'b0);
    run("R8 w1 161", -8, 4, 0, 72, 72, 161, 296, 592, 1'b1);
    run("R8 w1 128", -8, 4, 0, 72, 72, 128, 230, 460, 1'b0);
    run("R8 w1 127", -8, 4, 0, 72, 72, 127, 228, 456, 1'b1);
    run("R9 w2 282", -8, 4, 0, 72, 72, 144, 282, 564, 1'b0);
    run("R9 w2 283", -8, 4, 0, 72, 72, 144, 283, 566, 1'b1);
    run("R9 w2 242", -8, 4, 0, 72, 72, 144, 242, 484, 1'b0);
    run("R9 w2 241", -8, 4, 0, 72, 72, 144, 241, 482, 1'b1);
    run("R10 w3 560", -8, 4, 0, 72, 72, 144, 262, 560, 1'b0);
    run("R10 w3 561", -8, 4, 0, 72, 72, 144, 262, 561, 1'b1);
    run("R10 w3 488", -8, 4, 0, 72, 72, 144, 262, 488, 1'b0);
    run("R10 w3 487", -8, 4, 0, 72, 72, 144, 262, 487, 1'b1);
  endtask

  task automatic t_combined;
    // Window centre for wt2 is 6, lower edge -14: zero must pass, not wrap.
    run("R11 low window no wrap", -8, 4, 0, 30, 16, 16, 0, 0, 1'b0);
    run("R11 many failures", 100, 30, -30, 200, 0, 900, 0, 1000, 1'b1);
    run_nominal("R11 nominal pass", 1'b0);
  endtask

  task automatic t_hold;
    run("R2 latch fail", 23, 4, 0, 72, 72, 144, 262, 524, 1'b1);
    @(negedge clk);
    set_words(-8, 4, 0, 72, 72, 144, 262, 524);
    repeat (3) @(negedge clk);
    check("R2 held without strobe", cal_fail, 1'b1);
    run_nominal("R2 strobe updates", 1'b0);
    @(negedge clk);
    set_words(23, 4, 0, 72, 72, 144, 262, 524);
    repeat (3) @(negedge clk);
    check("R2 pass held without strobe", cal_fail, 1'b0);
  endtask

  task automatic t_reset_vs_strobe;
    run("R1 pre-latch fail", 23, 4, 0, 72, 72, 144, 262, 524, 1'b1);
    @(negedge clk);
    set_words(23, 4, 0, 72, 72, 144, 262, 524);
    rst = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    check("R1 reset beats strobe", cal_fail, 1'b0);
  endtask

  initial begin
    t_reset();
    run_nominal("R2 nominal", 1'b0);
    t_offset();
    t_trims();
    t_base();
    t_chain();
    t_combined();
    t_hold();
    t_reset_vs_strobe();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: act=timeout exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule